// File: doc/BRIEF.md
# Flash Status Register with Sticky Failure Flags

This block holds the status word of a flash device's program/erase engine and presents it to the host bus. The engine side is modelled by a request/grant handshake plus done, fail, abort, suspend-request, suspend-reached and resume pulses. A clear command from the command decoder resets the failure flags. Two sector-protect inputs supply the protect summary bit.

The two failure flags are sticky. The engine can set them, but only the host's clear command returns them to zero. While either flag is set, the block refuses any new program or erase request.

The host reads the status through active-low chip-enable and output-enable strobes. Both strobes are synchronised to the system clock. The status word is captured once, when the later of the two strobes falls, and is held until a strobe rises. A status change during a read therefore never shows up half-way through that read. In word mode the block drives all 16 data lanes. In byte mode it drives only the low byte and releases the upper lanes.

Top module: `flash_status_unit`

## Requirements
- R1: The status byte carries ready/not-busy in bit 7, erase-suspended in bit 6, erase-failed in bit 5, program-failed in bit 4 and protect summary in bit 3. Bits 2..0 always read 0.
- R2: After reset, bits 7..4 read 1000b and no data lane is enabled.
- R3: A granted request clears bit 7 on the next clock. An engine done pulse while busy sets bit 7 again. A done pulse while idle has no effect.
- R4: An engine fail pulse while busy sets bit 7 together with bit 5 for an erase or bit 4 for a program. Bits 5 and 4 stay set until a clear pulse, and the clear pulse zeroes both. If a set and a clear arrive in the same cycle, the set wins.
- R5: An abort while an operation is active or suspended sets bit 7, clears bit 6, and sets bit 5 for an erase or bit 4 for a program.
- R6: `op_grant_o` is 1 only when a request arrives while bit 7 is 1, bit 6 is 0, and bits 5 and 4 are 0.
- R7: A suspend request during an erase sets bit 6 on the next clock, with bit 7 still 0. Suspend-reached then sets bit 7. Resume clears bits 6 and 7. A suspend request during a program is ignored.
- R8: Bit 3 equals (top protect OR bottom protect), registered once. The clear command does not change it.
- R9: The status byte is captured three clocks after the later of the two strobes falls, and lane enables assert in that same cycle. The value stays constant while both strobes remain low. A strobe must rise and fall again to show a newer value.
- R10: In word mode (`byte_mode_i`=0) the upper byte is driven as 00h with its enable set. In byte mode the upper-lane enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byte_mode_i | input | 1 | 1 = byte bus, 0 = word bus |
| ce_ni | input | 1 | Chip-enable read strobe, active low, asynchronous |
| oe_ni | input | 1 | Output-enable read strobe, active low, asynchronous |
| op_req_i | input | 1 | Request to start a program or erase |
| op_erase_i | input | 1 | Kind of request: 1 = erase, 0 = program |
| op_grant_o | output | 1 | Request accepted this cycle |
| eng_done_i | input | 1 | Engine finished successfully |
| eng_fail_i | input | 1 | Engine finished with a failure |
| abort_i | input | 1 | Abort the active or suspended operation |
| susp_req_i | input | 1 | Erase suspend command |
| susp_reached_i | input | 1 | Engine has reached its suspend idle state |
| resume_i | input | 1 | Erase resume command |
| clr_i | input | 1 | Clear-status command |
| prot_top_i | input | 1 | Top sector protected |
| prot_bot_i | input | 1 | Bottom sector protected |
| data_o | output | 16 | Read data lanes |
| data_oe_o | output | 2 | Per-byte lane drive enables |

## Verification
The bound checker covers four properties on every clock:
- the failure flags never drop without a clear command;
- no grant is issued while a failure flag is set;
- a grant is always followed by busy, and a suspend never raises bit 6 together with bit 7;
- while a read stays open, the driven byte is stable, bits 2..0 are zero, and the lane rules hold.

Other behaviour needs the bench's scenarios. These are:
- the full order of engine events and the status each one produces;
- the suspend-during-program case;
- the later-strobe capture point, and the need to toggle a strobe before a new value appears;
- protect-bit isolation from the clear command.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int unsigned STS_W   = 8;
  localparam int unsigned B_READY = 7;
  localparam int unsigned B_SUSP  = 6;
  localparam int unsigned B_EFAIL = 5;
  localparam int unsigned B_PFAIL = 4;
  localparam int unsigned B_PROT  = 3;

  typedef struct packed {
    logic ready;
    logic susp;
    logic efail;
    logic pfail;
    logic prot;
    logic [2:0] rsvd;
  } sts_t;
endpackage

// File: rtl/fsu_strobe_sync.sv
module fsu_strobe_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '1;  // strobes idle high
      else if (s == 0) chain_q[s] <= async_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/fsu_flags.sv
module fsu_flags
  import fsu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic op_req_i,
  input  logic op_erase_i,
  output logic op_grant_o,
  input  logic eng_done_i,
  input  logic eng_fail_i,
  input  logic abort_i,
  input  logic susp_req_i,
  input  logic susp_reached_i,
  input  logic resume_i,
  input  logic clr_i,
  input  logic prot_top_i,
  input  logic prot_bot_i,
  output sts_t sts_o
);
  logic ready_q, susp_q, efail_q, pfail_q, erase_q, prot_q;
  logic busy;

  assign busy       = !ready_q && !susp_q;
  assign op_grant_o = op_req_i && ready_q && !susp_q && !efail_q && !pfail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prot_q <= 1'b0;
    else         prot_q <= prot_top_i | prot_bot_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b1;
      susp_q  <= 1'b0;
      efail_q <= 1'b0;
      pfail_q <= 1'b0;
      erase_q <= 1'b0;
    end else begin
      // clear first; any set below in the same cycle overrides it
      if (clr_i) begin
        efail_q <= 1'b0;
        pfail_q <= 1'b0;
      end
      if (op_grant_o) begin
        ready_q <= 1'b0;
        erase_q <= op_erase_i;
      end else if (abort_i && (busy || susp_q)) begin
        ready_q <= 1'b1;
        susp_q  <= 1'b0;
        if (erase_q) efail_q <= 1'b1;
        else         pfail_q <= 1'b1;
      end else if (busy) begin
        if (eng_fail_i) begin
          ready_q <= 1'b1;
          if (erase_q) efail_q <= 1'b1;
          else         pfail_q <= 1'b1;
        end else if (eng_done_i) begin
          ready_q <= 1'b1;
        end else if (susp_req_i && erase_q) begin
          susp_q <= 1'b1;
        end
      end else if (susp_q && !ready_q && susp_reached_i) begin
        ready_q <= 1'b1;
      end else if (susp_q && ready_q && resume_i) begin
        susp_q  <= 1'b0;
        ready_q <= 1'b0;
      end
    end
  end

  always_comb begin
    sts_o       = '0;
    sts_o.ready = ready_q;
    sts_o.susp  = susp_q;
    sts_o.efail = efail_q;
    sts_o.pfail = pfail_q;
    sts_o.prot  = prot_q;
  end
endmodule

// File: rtl/fsu_bus_drive.sv
module fsu_bus_drive #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_s_i,
  input  logic              byte_mode_i,
  input  logic [BYTE_W-1:0] sts_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W/BYTE_W-1:0] data_oe_o
);
  localparam int unsigned LANES = DATA_W / BYTE_W;

  logic              rd_q;
  logic [BYTE_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      snap_q <= '0;
    end else begin
      rd_q <= rd_s_i;
      if (rd_s_i && !rd_q) snap_q <= sts_i;  // later strobe fell
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_low
      assign data_o[BYTE_W-1:0] = snap_q;
      assign data_oe_o[0]       = rd_q;
    end else begin : g_up
      assign data_o[l*BYTE_W +: BYTE_W] = '0;
      assign data_oe_o[l]               = rd_q && !byte_mode_i;
    end
  end
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_mode_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              op_req_i,
  input  logic              op_erase_i,
  output logic              op_grant_o,
  input  logic              eng_done_i,
  input  logic              eng_fail_i,
  input  logic              abort_i,
  input  logic              susp_req_i,
  input  logic              susp_reached_i,
  input  logic              resume_i,
  input  logic              clr_i,
  input  logic              prot_top_i,
  input  logic              prot_bot_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W/8-1:0] data_oe_o
);
  import fsu_pkg::*;

  localparam int unsigned BYTE_W = 8;

  sts_t             sts;
  logic [STS_W-1:0] status_w;
  logic [1:0]       strobe_s;
  logic             rd_s;

  fsu_strobe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ce_ni, oe_ni}),
    .sync_o  (strobe_s)
  );

  assign rd_s = !strobe_s[1] && !strobe_s[0];

  fsu_flags u_flags (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .op_req_i       (op_req_i),
    .op_erase_i     (op_erase_i),
    .op_grant_o     (op_grant_o),
    .eng_done_i     (eng_done_i),
    .eng_fail_i     (eng_fail_i),
    .abort_i        (abort_i),
    .susp_req_i     (susp_req_i),
    .susp_reached_i (susp_reached_i),
    .resume_i       (resume_i),
    .clr_i          (clr_i),
    .prot_top_i     (prot_top_i),
    .prot_bot_i     (prot_bot_i),
    .sts_o          (sts)
  );

  assign status_w = sts;

  fsu_bus_drive #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_s_i      (rd_s),
    .byte_mode_i (byte_mode_i),
    .sts_i       (status_w),
    .data_o      (data_o),
    .data_oe_o   (data_oe_o)
  );
endmodule

// File: rtl/fsu_checker.sv
module fsu_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  status_i,
  input logic        clr_i,
  input logic        grant_i,
  input logic        byte_mode_i,
  input logic [15:0] data_o,
  input logic [1:0]  data_oe_o
);
  assert_pfail_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[4] && !clr_i) |=> status_i[4]);
  assert_efail_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[5] && !clr_i) |=> status_i[5]);
  assert_no_grant_on_fail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[5] || status_i[4]) |-> !grant_i);
  assert_grant_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |=> !status_i[7]);
  assert_susp_before_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_i[6]) |-> !status_i[7]);
  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o[0] |-> (data_o[2:0] == 3'b000));
  assert_snap_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o[0] && $past(data_oe_o[0])) |-> $stable(data_o[7:0]));
  assert_upper_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o[1] |-> (data_o[15:8] == 8'h00));
  assert_byte_mode_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_mode_i |-> !data_oe_o[1]);
endmodule

bind flash_status_unit fsu_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .status_i    (status_w),
  .clr_i       (clr_i),
  .grant_i     (op_grant_o),
  .byte_mode_i (byte_mode_i),
  .data_o      (data_o),
  .data_oe_o   (data_oe_o)
);

// File: tb/flash_status_unit_bench.sv
module flash_status_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_mode = 1'b0, ce_n = 1'b1, oe_n = 1'b1;
  logic req = 0, erase = 0, done = 0, fail = 0, abort = 0;
  logic sreq = 0, sreach = 0, resume = 0, clr = 0, ptop = 0, pbot = 0;
  logic        grant;
  logic [15:0] data;
  logic [1:0]  doe;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flash_status_unit u_flash_status_unit (
    .clk_i(clk), .rst_ni(rst_n), .byte_mode_i(byte_mode), .ce_ni(ce_n), .oe_ni(oe_n),
    .op_req_i(req), .op_erase_i(erase), .op_grant_o(grant), .eng_done_i(done),
    .eng_fail_i(fail), .abort_i(abort), .susp_req_i(sreq), .susp_reached_i(sreach),
    .resume_i(resume), .clr_i(clr), .prot_top_i(ptop), .prot_bot_i(pbot),
    .data_o(data), .data_oe_o(doe)
  );

  // action codes: 1 req program, 2 req erase, 3 done, 4 fail, 5 abort,
  // 6 suspend, 7 reached, 8 resume, 9 clear; {action, grant_exp, status_exp}
  localparam logic [12:0] VEC [21] = '{
    {4'd1, 1'b1, 8'h00}, {4'd3, 1'b0, 8'h80}, {4'd2, 1'b1, 8'h00},
    {4'd6, 1'b0, 8'h40}, {4'd7, 1'b0, 8'hC0}, {4'd1, 1'b0, 8'hC0},
    {4'd8, 1'b0, 8'h00}, {4'd4, 1'b0, 8'hA0}, {4'd1, 1'b0, 8'hA0},
    {4'd9, 1'b0, 8'h80}, {4'd1, 1'b1, 8'h00}, {4'd5, 1'b0, 8'h90},
    {4'd9, 1'b0, 8'h80}, {4'd2, 1'b1, 8'h00}, {4'd5, 1'b0, 8'hA0},
    {4'd9, 1'b0, 8'h80}, {4'd1, 1'b1, 8'h00}, {4'd6, 1'b0, 8'h00},
    {4'd4, 1'b0, 8'h90}, {4'd3, 1'b0, 8'h90}, {4'd9, 1'b0, 8'h80}
  };

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic g_exp);
    @(negedge clk);
    req = (a == 1) || (a == 2); erase = (a == 2); done = (a == 3); fail = (a == 4);
    abort = (a == 5); sreq = (a == 6); sreach = (a == 7); resume = (a == 8); clr = (a == 9);
    #1 check("R6 grant", {31'd0, grant}, {31'd0, g_exp});
    @(negedge clk);
    {req, erase, done, fail, abort, sreq, sreach, resume, clr} = '0;
  endtask

  task automatic open_read;
    @(negedge clk); ce_n = 0; oe_n = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic close_read;
    @(negedge clk); ce_n = 1; oe_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_sts(output logic [7:0] v);
    open_read();
    v = data[7:0];
    close_read();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R2 oe at reset", {30'd0, doe}, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R2 oe idle", {30'd0, doe}, 32'd0);
    open_read();
    check("R2 reset status", {24'd0, data[7:0]}, 32'h80);
    check("R10 word lanes", {30'd0, doe}, 32'd3);
    check("R10 upper byte", {24'd0, data[15:8]}, 32'd0);
    check("R1 reserved", {29'd0, data[2:0]}, 32'd0);
    close_read();

    for (int i = 0; i < 21; i++) begin
      apply(VEC[i][12:9], VEC[i][8]);
      read_sts(v);
      check($sformatf("R3 R4 R5 R7 step %0d", i), {24'd0, v}, {24'd0, VEC[i][7:0]});
    end

    // R8 protect summary, untouched by clear
    ptop = 1; apply(4'd9, 1'b0); read_sts(v);
    check("R8 top protect", {24'd0, v}, 32'h88);
    ptop = 0; pbot = 1; repeat (2) @(negedge clk); read_sts(v);
    check("R8 bottom protect", {24'd0, v}, 32'h88);
    pbot = 0; repeat (2) @(negedge clk); read_sts(v);
    check("R8 none", {24'd0, v}, 32'h80);

    // R10 byte mode
    byte_mode = 1; open_read();
    check("R10 byte lanes", {30'd0, doe}, 32'd1);
    close_read(); byte_mode = 0;

    // R9 hold while open, refresh after toggle
    open_read();
    apply(4'd1, 1'b1);
    repeat (2) @(negedge clk);
    check("R9 held value", {24'd0, data[7:0]}, 32'h80);
    @(negedge clk); oe_n = 1; repeat (4) @(negedge clk);
    check("R9 oe high releases", {30'd0, doe}, 32'd0);
    @(negedge clk); oe_n = 0; repeat (4) @(negedge clk);
    check("R9 new value after toggle", {24'd0, data[7:0]}, 32'h00);
    close_read();

    // R9 capture at later strobe: ce low early, status changes, then oe low
    @(negedge clk); ce_n = 0; repeat (4) @(negedge clk);
    check("R9 ce only no drive", {30'd0, doe}, 32'd0);
    apply(4'd3, 1'b0);
    @(negedge clk); oe_n = 0;
    repeat (2) @(negedge clk);
    check("R9 not yet driven", {30'd0, doe}, 32'd0);
    @(negedge clk);
    check("R9 driven third clock", {30'd0, doe}, 32'd3);
    check("R9 later edge value", {24'd0, data[7:0]}, 32'h80);
    close_read();

    // R4 set wins over simultaneous clear
    apply(4'd1, 1'b1);
    @(negedge clk); fail = 1; clr = 1; @(negedge clk); fail = 0; clr = 0;
    read_sts(v);
    check("R4 set beats clear", {24'd0, v}, 32'h90);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule